// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block stands in for the device side of a parallel NOR flash while an embedded program or erase is running. It keeps a small word array and a command sequencer. A read strobe normally returns array contents. While an operation is under way, the same read returns a live 8-bit status word. That word carries a polling bit, two toggle bits, a time-limit failure flag, an erase-window flag and a buffer-abort flag. A registered ready output falls when an operation starts and rises when it ends.

Commands arrive already decoded, one per cycle: program one word, queue a sector for erase, suspend, resume, return to read mode, and clear a buffer abort. Operation lengths and the multi-sector acceptance window are parameters counted in clock cycles. A failure-injection input makes the running operation end in the time-limit state. A one-cycle abort event puts the block into the buffer-abort state.

Top module: `nor_opstat_top`

## Requirements
- R1: After a synchronous reset, ready is 1 and rd_data is 0.
- R2: In read mode, the word returned one cycle after a read strobe is the array word at rd_addr. A program command stores its data at its address after PROG_CYC cycles.
- R3: While a program runs, status bit 7 reads as the complement of bit 7 of the data being programmed. Once the program is done, a read of that address returns the true data.
- R4: While a program, erase window, erase or failure state is active, status bit 6 inverts on each read strobe at any address. Once read mode returns, reads give array data and no longer change.
- R5: If fail_inject is high when an operation would complete, the block enters a failure state. In that state bit 5 reads 1, bit 6 keeps inverting and ready stays 0. Only the reset command (code 5) leaves it, and the failed program leaves the array word unchanged.
- R6: A sector-erase command (code 2) opens an acceptance window of WIN_CYC cycles in which bit 3 reads 0. Each further sector-erase command inside the window adds its sector and restarts the window. After expiry, bit 3 reads 1 and the erase runs.
- R7: During the erase, bit 7 reads 0 at addresses in a queued sector. Commands other than suspend are ignored. After completion, every word of the queued sectors reads all ones and other sectors are unchanged.
- R8: After suspend (code 3), ready is 1. Reads of a suspended sector show bit 2 inverting and bit 6 steady, and reads elsewhere return array data. After resume (code 4), both bits invert on each read.
- R9: A wbuf_abort pulse in read mode gives a status word with bit 1 set at every address. The reset command leaves it in place, and only the abort-clear command (code 6) returns to read mode.
- R10: ready is 0 during program, erase window, erase and failure, and 1 in read mode, suspend and buffer abort.
- R11: In a status word, bits 4 and 0 and all bits above bit 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code: 1 program, 2 sector erase, 3 suspend, 4 resume, 5 reset, 6 abort clear |
| cmd_addr | input | ADDR_W | Word address (top SECT_W bits select the sector) |
| cmd_data | input | DATA_W | Program data |
| fail_inject | input | 1 | Forces the completing operation into the failure state |
| wbuf_abort | input | 1 | One-cycle buffer-write abort event |
| rd_en | input | 1 | Completed read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array word or status word, valid the cycle after rd_en |
| ready | output | 1 | 1 when no operation is running |

## Verification
The bench places sector-erase commands late in the acceptance window, so that the total elapsed time exceeds one window. A design that failed to restart the window would already show bit 3 set, and would erase too few sectors. It reads a suspended sector twice and expects bit 2 to change while bit 6 holds. A design that toggled both bits, or neither, would break this check. It sends a program command in the middle of an erase and checks that the target word survives. It also checks that a plain reset command does not clear a buffer abort, and that a failure cannot be left by any command except reset. Random programs compare the polled bit 7 and the final data against a bench copy of the array.

// File: rtl/nor_opstat_pkg.sv
package nor_opstat_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_SERASE    = 3'd2,
    OP_SUSPEND   = 3'd3,
    OP_RESUME    = 3'd4,
    OP_RESET     = 3'd5,
    OP_ABORT_CLR = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_EWIN, ST_ERASE, ST_ESUSP, ST_FAIL, ST_ABORT
  } st_e;

  localparam int B_POLL  = 7;
  localparam int B_TOG   = 6;
  localparam int B_LIMIT = 5;
  localparam int B_EWIN  = 3;
  localparam int B_TOG2  = 2;
  localparam int B_ABORT = 1;
endpackage

// File: rtl/nor_opstat_seq.sv
module nor_opstat_seq
  import nor_opstat_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 20,
  parameter int WIN_CYC   = 30,
  parameter int ERASE_CYC = 80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  op_e                   cmd_op,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  input  logic                  fail_inject,
  input  logic                  wbuf_abort,
  output st_e                   st,
  output logic [(1<<SECT_W)-1:0] sect_mask,
  output logic [DATA_W-1:0]     prog_data,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  ready
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NSECT   = 1 << SECT_W;
  localparam int CNT_MAX = (PROG_CYC > WIN_CYC) ?
                           ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) :
                           ((WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] SWEEP_END  = CNT_W'(DEPTH);

  initial begin
    if (ERASE_CYC <= DEPTH) $error("ERASE_CYC must exceed the array depth");
  end

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] prog_addr;
  logic [NSECT-1:0]  cmd_sect;
  logic [ADDR_W-1:0] sweep_addr;
  logic              is_cmd_prog, is_cmd_erase;

  assign is_cmd_prog  = cmd_valid && (cmd_op == OP_PROG);
  assign is_cmd_erase = cmd_valid && (cmd_op == OP_SERASE);
  assign sweep_addr   = cnt[ADDR_W-1:0];

  always_comb begin
    cmd_sect = '0;
    cmd_sect[cmd_addr[ADDR_W-1 -: SECT_W]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sect_mask <= '0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (is_cmd_prog) begin
            st        <= ST_PROG;
            prog_addr <= cmd_addr;
            prog_data <= cmd_data;
          end else if (is_cmd_erase) begin
            st        <= ST_EWIN;
            sect_mask <= cmd_sect;
          end else if (wbuf_abort) begin
            st <= ST_ABORT;
          end
        end
        ST_PROG: begin
          if (cnt == PROG_LAST) begin
            st  <= fail_inject ? ST_FAIL : ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EWIN: begin
          if (is_cmd_erase) begin
            sect_mask <= sect_mask | cmd_sect;
            cnt       <= '0;
          end else if (cnt == WIN_LAST) begin
            st  <= ST_ERASE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ERASE: begin
          if (cmd_valid && cmd_op == OP_SUSPEND) begin
            st <= ST_ESUSP;
          end else if (cnt == ERASE_LAST) begin
            cnt <= '0;
            if (fail_inject) begin
              st <= ST_FAIL;
            end else begin
              st        <= ST_IDLE;
              sect_mask <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ESUSP: begin
          if (cmd_valid && cmd_op == OP_RESUME) st <= ST_ERASE;
        end
        ST_FAIL: begin
          if (cmd_valid && cmd_op == OP_RESET) begin
            st        <= ST_IDLE;
            sect_mask <= '0;
            cnt       <= '0;
          end
        end
        ST_ABORT: begin
          if (cmd_valid && cmd_op == OP_ABORT_CLR) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Single array write port: program commit or erase sweep.
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = sweep_addr;
    wr_data = '1;
    if (st == ST_PROG) begin
      wr_en   = (cnt == PROG_LAST) && !fail_inject;
      wr_addr = prog_addr;
      wr_data = prog_data;
    end else if (st == ST_ERASE) begin
      wr_en = (cnt < SWEEP_END) && sect_mask[sweep_addr[ADDR_W-1 -: SECT_W]];
    end
  end

  assign ready = !(st == ST_PROG || st == ST_EWIN || st == ST_ERASE || st == ST_FAIL);
endmodule

// File: rtl/nor_opstat_array.sv
module nor_opstat_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/nor_opstat_rdpath.sv
module nor_opstat_rdpath
  import nor_opstat_pkg::*;
#(
  parameter int SECT_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [SECT_W-1:0]      rd_sect,
  input  st_e                    st,
  input  logic [(1<<SECT_W)-1:0] sect_mask,
  input  logic                   prog_bit7,
  input  logic [DATA_W-1:0]      arr_q,
  output logic [DATA_W-1:0]      rd_data
);
  logic       tog6, tog2, sel_q;
  logic [7:0] stat_q, stat_d;
  logic       in_sect, busy_t, t2_cond, show_stat;
  logic [DATA_W-1:0] stat_ext;

  assign in_sect   = sect_mask[rd_sect];
  assign busy_t    = (st == ST_PROG) || (st == ST_EWIN) || (st == ST_ERASE) || (st == ST_FAIL);
  assign t2_cond   = in_sect && ((st == ST_ERASE) || (st == ST_ESUSP));
  assign show_stat = busy_t || (st == ST_ABORT) || ((st == ST_ESUSP) && in_sect);

  always_comb begin
    stat_d          = '0;
    stat_d[B_POLL]  = (st == ST_PROG) ? ~prog_bit7 : 1'b0;
    stat_d[B_TOG]   = tog6;
    stat_d[B_LIMIT] = (st == ST_FAIL);
    stat_d[B_EWIN]  = (st == ST_ERASE) || (st == ST_ESUSP);
    stat_d[B_TOG2]  = tog2;
    stat_d[B_ABORT] = (st == ST_ABORT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog6   <= 1'b0;
      tog2   <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else if (rd_en) begin
      sel_q  <= show_stat;
      stat_q <= stat_d;
      if (busy_t)  tog6 <= ~tog6;
      if (t2_cond) tog2 <= ~tog2;
    end
  end

  always_comb begin
    stat_ext      = '0;
    stat_ext[7:0] = stat_q;
  end

  assign rd_data = sel_q ? stat_ext : arr_q;
endmodule

// File: rtl/nor_opstat_top.sv
module nor_opstat_top
  import nor_opstat_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 20,
  parameter int WIN_CYC   = 30,
  parameter int ERASE_CYC = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              fail_inject,
  input  logic              wbuf_abort,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  localparam int NSECT = 1 << SECT_W;

  st_e               st_w;
  logic [NSECT-1:0]  mask_w;
  logic [DATA_W-1:0] pdata_w, wdata_w, arr_w;
  logic [ADDR_W-1:0] waddr_w;
  logic              wen_w;

  nor_opstat_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
  ) seq_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_e'(cmd_op)),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fail_inject(fail_inject),
    .wbuf_abort(wbuf_abort), .st(st_w), .sect_mask(mask_w), .prog_data(pdata_w),
    .wr_en(wen_w), .wr_addr(waddr_w), .wr_data(wdata_w), .ready(ready)
  );

  nor_opstat_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .rst(rst), .wr_en(wen_w), .wr_addr(waddr_w), .wr_data(wdata_w),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(arr_w)
  );

  nor_opstat_rdpath #(.SECT_W(SECT_W), .DATA_W(DATA_W)) rdpath_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]),
    .st(st_w), .sect_mask(mask_w), .prog_bit7(pdata_w[7]), .arr_q(arr_w),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/nor_opstat_chk.sv
module nor_opstat_chk
  import nor_opstat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input st_e               st,
  input logic              pdata7
);
  assert_fail_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAIL && !(cmd_valid && cmd_op == 3'(OP_RESET))) |=> st == ST_FAIL);

  assert_limit_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && st == ST_FAIL) |=> rd_data[5]);

  assert_abort_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ABORT && !(cmd_valid && cmd_op == 3'(OP_ABORT_CLR))) |=> st == ST_ABORT);

  assert_poll_inv_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && st == ST_PROG) |=> rd_data[7] == ~$past(pdata7));

  assert_tog_flip_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && st == ST_PROG && $past(rd_en) && $past(st) == ST_PROG)
      |=> rd_data[6] != $past(rd_data[6]));

  assert_erase_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE && cmd_valid && cmd_op == 3'(OP_PROG)) |=> st != ST_PROG);

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && st == ST_PROG) |=> (!rd_data[4] && !rd_data[0]));
endmodule

bind nor_opstat_top nor_opstat_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rd_en(rd_en), .rd_data(rd_data), .st(st_w), .pdata7(pdata_w[7])
);

// File: tb/nor_opstat_top_tb_top.sv
`timescale 1ns/1ps
module nor_opstat_top_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int WC = 30;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic fail_inject = 1'b0;
  logic wbuf_abort = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  nor_opstat_top dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .fail_inject(fail_inject),
    .wbuf_abort(wbuf_abort), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ready(ready)
  );

  function automatic logic [7:0] poll_expect(input logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] q);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (!ready && k < 2000) begin @(negedge clk); k++; end
    check(req, {7'b0, ready}, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] q, q2, d;
    logic [AW-1:0] a, b;
    int k;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1
    check("R1 ready", {7'b0, ready}, 8'h01);
    check("R1 rd_data", rd_data, 8'h00);

    // R6: four sectors joined late in the window, restart proven by elapsed time
    cmd(3'd2, 6'd0, 8'h00);
    check("R10 busy in window", {7'b0, ready}, 8'h00);
    idle(WC - 8);
    rd(6'd1, q);
    check("R6 window open", {7'b0, q[3]}, 8'h00);
    cmd(3'd2, 6'd16, 8'h00);
    idle(WC - 8);
    rd(6'd1, q);
    check("R6 window restarted", {7'b0, q[3]}, 8'h00);
    cmd(3'd2, 6'd32, 8'h00);
    cmd(3'd2, 6'd48, 8'h00);
    k = 0;
    q = 8'h00;
    while (!q[3] && k < 200) begin rd(6'd2, q); k++; end
    check("R6 window expired", {7'b0, q[3]}, 8'h01);
    rd(6'd50, q);
    check("R7 erase poll bit7", {7'b0, q[7]}, 8'h00);
    wait_ready("R7 erase done");
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    rd(6'd0, q);  check("R7 erased word s0", q, 8'hFF);
    rd(6'd63, q); check("R7 erased word s3", q, 8'hFF);

    // R2/R3/R4: random programs
    for (int i = 0; i < 12; i++) begin
      a = AW'($urandom % DEPTH);
      b = a ^ 6'h21;
      d = 8'($urandom);
      cmd(3'd1, a, d);
      check("R10 busy in program", {7'b0, ready}, 8'h00);
      rd(a, q);
      check("R3 bit7 complement", q & 8'h80, poll_expect(d));
      check("R11 reserved bits", q & 8'h11, 8'h00);
      rd(b, q); rd(b, q2);
      check("R4 bit6 toggles", {7'b0, q[6] ^ q2[6]}, 8'h01);
      wait_ready("R2 program done");
      model[a] = d;
      rd(a, q);
      check("R3 true data after program", q, d);
      rd(b, q); rd(b, q2);
      check("R4 toggling stops", q2, model[b]);
      check("R4 array data", q, model[b]);
    end

    // R5: failure state
    fail_inject = 1'b1;
    cmd(3'd1, 6'd5, 8'h3C);
    idle(30);
    fail_inject = 1'b0;
    check("R5 ready low", {7'b0, ready}, 8'h00);
    rd(6'd9, q); rd(6'd9, q2);
    check("R5 bit5 set", {7'b0, q[5]}, 8'h01);
    check("R5 bit6 still toggles", {7'b0, q[6] ^ q2[6]}, 8'h01);
    cmd(3'd6, 6'd0, 8'h00);
    cmd(3'd1, 6'd5, 8'h00);
    rd(6'd9, q);
    check("R5 other commands ignored", {7'b0, q[5]}, 8'h01);
    cmd(3'd5, 6'd0, 8'h00);
    check("R5 reset restores ready", {7'b0, ready}, 8'h01);
    rd(6'd5, q);
    check("R5 word unchanged", q, model[5]);

    // R7/R8: erase with suspend and resume
    cmd(3'd1, 6'd19, 8'hA5); wait_ready("R2 prog s1"); model[19] = 8'hA5;
    cmd(3'd1, 6'd36, 8'h5A); wait_ready("R2 prog s2"); model[36] = 8'h5A;
    cmd(3'd2, 6'd16, 8'h00);
    k = 0; q = 8'h00;
    while (!q[3] && k < 200) begin rd(6'd17, q); k++; end
    check("R6 erase started", {7'b0, q[3]}, 8'h01);
    cmd(3'd3, 6'd0, 8'h00);
    check("R8 ready in suspend", {7'b0, ready}, 8'h01);
    rd(6'd17, q); rd(6'd17, q2);
    check("R8 bit2 toggles", {7'b0, q[2] ^ q2[2]}, 8'h01);
    check("R8 bit6 steady", {7'b0, q[6] ^ q2[6]}, 8'h00);
    rd(6'd36, q);
    check("R8 other sector array data", q, model[36]);
    cmd(3'd4, 6'd0, 8'h00);
    check("R10 busy after resume", {7'b0, ready}, 8'h00);
    rd(6'd17, q); rd(6'd17, q2);
    check("R8 bit2 toggles after resume", {7'b0, q[2] ^ q2[2]}, 8'h01);
    check("R8 bit6 toggles after resume", {7'b0, q[6] ^ q2[6]}, 8'h01);
    rd(6'd18, q);
    check("R7 bit7 low in erasing sector", {7'b0, q[7]}, 8'h00);
    cmd(3'd1, 6'd36, 8'h00);
    wait_ready("R7 erase done");
    for (int i = 16; i < 32; i++) model[i] = 8'hFF;
    rd(6'd36, q);
    check("R7 program during erase ignored", q, 8'h5A);
    rd(6'd19, q);
    check("R7 sector word erased", q, 8'hFF);
    rd(6'd17, q); rd(6'd17, q2);
    check("R8 toggling stops after erase", q2, 8'hFF);

    // R9: buffer abort
    wbuf_abort = 1'b1; @(posedge clk); @(negedge clk); wbuf_abort = 1'b0;
    check("R10 ready in abort", {7'b0, ready}, 8'h01);
    rd(6'd40, q);
    check("R9 bit1 set", q & 8'h2A, 8'h02);
    cmd(3'd5, 6'd0, 8'h00);
    rd(6'd3, q);
    check("R9 plain reset ignored", {7'b0, q[1]}, 8'h01);
    cmd(3'd6, 6'd0, 8'h00);
    rd(6'd40, q);
    check("R9 abort clear restores array", q, model[40]);

    // R2: random read sweep
    for (int i = 0; i < 20; i++) begin
      a = AW'($urandom % DEPTH);
      rd(a, q);
      check("R2 random read", q, model[a]);
    end

    finish_run();
  end
endmodule